// File: doc/BRIEF.md
# Fixed-Point Eight-Point Row Inverse Transform

This block takes one row of eight signed 16-bit transform coefficients and returns eight signed 16-bit spatial samples. Inside, the work splits into an even half and an odd half. Four even sums combine only the even-indexed coefficients, and four odd sums combine only the odd-indexed ones. Each sum is a four-term multiply-accumulate with 16-bit constant weights. A butterfly then adds and subtracts the two halves. Each result is shifted right arithmetically by 11 bits and clipped to the 16-bit range.

The scaling of the weights depends on where the row sits in an 8x8 block. Four weight sets are built in, and the row index selects one of them together with a per-row rounding constant. A row can be presented on every clock cycle. Each result appears a fixed two cycles later, flagged by its own valid strobe. A larger two-dimensional transform uses this block for its first, row-wise pass.

Top module: `row_idct8`

## Requirements
- R1: When `in_valid` is sampled high at a rising edge, `out_valid` is high after the second rising edge that follows, carrying that row's results. A new row is accepted on every cycle. `out_valid` is never high without an input two edges earlier.
- R2: While `rst_n` is low, and after its release until the first result, `out_valid` is 0 and `out_coefs` is all zeros.
- R3: The row index selects the weight set: rows 0 and 4 use set 0, rows 1 and 7 set 1, rows 2 and 6 set 2, rows 3 and 5 set 3. Each set is written as even constants (P,Q,R) and odd constants (A,B,C,D): set 0 = (16384,21407,8867 / 22725,19266,12873,4520), set 1 = (22725,29692,12299 / 31521,26722,17855,6270), set 2 = (21407,27969,11585 / 29692,25172,16819,5906), set 3 = (19266,25172,10426 / 26722,22654,15137,5315).
- R4: A rounding constant is added to every even sum. By row index 0..7 it is 65536, 3597, 2260, 1203, 0, 120, 512, 512. An all-zero row therefore yields 32 in every lane for row 0, and 0 in every lane for row 4.
- R5: The even sums use only x0,x2,x4,x6. With rnd the row's constant: e0=P·x0+Q·x2+P·x4+R·x6+rnd, e1=P·x0+R·x2−P·x4−Q·x6+rnd, e2=P·x0−R·x2−P·x4+Q·x6+rnd, e3=P·x0−Q·x2+P·x4−R·x6+rnd. The odd sums use only x1,x3,x5,x7: o0=A·x1+B·x3+C·x5+D·x7, o1=B·x1−D·x3−A·x5−C·x7, o2=C·x1−A·x3+D·x5+B·x7, o3=D·x1−C·x3+B·x5−A·x7. A row with zero odd coefficients gives y_k = y_(7−k).
- R6: For k=0..3, y_k = clip((e_k+o_k) >>> 11) and y_(7−k) = clip((e_k−o_k) >>> 11). All sums and differences are taken modulo 2^32 as signed 32-bit values, and the shift is arithmetic.
- R7: clip limits a shifted value to the range −32768..32767. Above that range the lane reads 0x7FFF, and below it 0x8000.
- R8: Coefficient x_j sits at `in_coefs[16j+15:16j]` and result y_j at `out_coefs[16j+15:16j]`, both two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Row present on the inputs this cycle |
| in_row | input | 3 | Row index 0..7 within the block |
| in_coefs | input | 128 | Eight signed 16-bit coefficients, x0 in the low bits |
| out_valid | output | 1 | Results present on `out_coefs` |
| out_coefs | output | 128 | Eight signed 16-bit results, y0 in the low bits |

## Verification
Two situations are hard to reach from the ports: a 32-bit accumulator that wraps, and a shifted value that must be clipped. Random coefficients seldom produce either, because typical magnitudes keep the sums well inside range. The stimulus therefore drives full-scale rows, single full-scale impulses and alternating-sign extremes through every row index, so that both the wrap and the clip at each limit are exercised. A back-to-back stream then mixes random rows with these extremes, showing that the row index and the rounding constant stay matched to their data through the pipeline.

// File: rtl/ridct_pkg.sv
package ridct_pkg;
  localparam int unsigned LANES = 8;
  localparam int unsigned HALF  = LANES / 2;
  localparam int unsigned XW    = 16;
  localparam int unsigned AW    = 32;
  localparam int unsigned SHIFT = 11;
  localparam int unsigned ROWW  = $clog2(LANES);
  localparam int unsigned SETW  = 2;
  localparam int unsigned BUSW  = LANES * XW;

  typedef logic signed [XW-1:0] samp_t;
  typedef logic signed [AW-1:0] acc_t;

  localparam acc_t SAT_MAX = acc_t'(32767);
  localparam acc_t SAT_MIN = -acc_t'(32768);

  // rows 0..3 map to themselves, rows 4..7 mirror: (8 - row) mod 4
  function automatic logic [SETW-1:0] set_of_row(input logic [ROWW-1:0] row);
    logic [ROWW-1:0] mirror;
    mirror = ROWW'(0) - row;
    return row[ROWW-1] ? mirror[SETW-1:0] : row[SETW-1:0];
  endfunction

  function automatic acc_t rounder_of_row(input logic [ROWW-1:0] row);
    case (row)
      3'd0:    return acc_t'(65536);
      3'd1:    return acc_t'(3597);
      3'd2:    return acc_t'(2260);
      3'd3:    return acc_t'(1203);
      3'd5:    return acc_t'(120);
      3'd6:    return acc_t'(512);
      3'd7:    return acc_t'(512);
      default: return acc_t'(0);
    endcase
  endfunction

  // even peaks: idx 0 = P, 1 = Q, 2 = R
  function automatic samp_t even_peak(input logic [SETW-1:0] set, input logic [1:0] idx);
    case ({set, idx})
      4'h0: return 16'sd16384; 4'h1: return 16'sd21407; 4'h2: return 16'sd8867;
      4'h4: return 16'sd22725; 4'h5: return 16'sd29692; 4'h6: return 16'sd12299;
      4'h8: return 16'sd21407; 4'h9: return 16'sd27969; 4'hA: return 16'sd11585;
      4'hC: return 16'sd19266; 4'hD: return 16'sd25172; 4'hE: return 16'sd10426;
      default: return 16'sd0;
    endcase
  endfunction

  // odd peaks: idx 0 = A, 1 = B, 2 = C, 3 = D
  function automatic samp_t odd_peak(input logic [SETW-1:0] set, input logic [1:0] idx);
    case ({set, idx})
      4'h0: return 16'sd22725; 4'h1: return 16'sd19266; 4'h2: return 16'sd12873; 4'h3: return 16'sd4520;
      4'h4: return 16'sd31521; 4'h5: return 16'sd26722; 4'h6: return 16'sd17855; 4'h7: return 16'sd6270;
      4'h8: return 16'sd29692; 4'h9: return 16'sd25172; 4'hA: return 16'sd16819; 4'hB: return 16'sd5906;
      default: case (idx)
        2'd0: return 16'sd26722; 2'd1: return 16'sd22654;
        2'd2: return 16'sd15137; default: return 16'sd5315;
      endcase
    endcase
  endfunction

  // {negate, peak index} for even output k, input j (j over x0,x2,x4,x6)
  function automatic logic [2:0] even_code(input logic [1:0] k, input logic [1:0] j);
    case ({k, j})
      4'h0: return 3'b000; 4'h1: return 3'b001; 4'h2: return 3'b000; 4'h3: return 3'b010;
      4'h4: return 3'b000; 4'h5: return 3'b010; 4'h6: return 3'b100; 4'h7: return 3'b101;
      4'h8: return 3'b000; 4'h9: return 3'b110; 4'hA: return 3'b100; 4'hB: return 3'b001;
      4'hC: return 3'b000; 4'hD: return 3'b101; 4'hE: return 3'b000; default: return 3'b110;
    endcase
  endfunction

  // {negate, peak index} for odd output k, input j (j over x1,x3,x5,x7)
  function automatic logic [2:0] odd_code(input logic [1:0] k, input logic [1:0] j);
    case ({k, j})
      4'h0: return 3'b000; 4'h1: return 3'b001; 4'h2: return 3'b010; 4'h3: return 3'b011;
      4'h4: return 3'b001; 4'h5: return 3'b111; 4'h6: return 3'b100; 4'h7: return 3'b110;
      4'h8: return 3'b010; 4'h9: return 3'b100; 4'hA: return 3'b011; 4'hB: return 3'b001;
      4'hC: return 3'b011; 4'hD: return 3'b110; 4'hE: return 3'b001; default: return 3'b100;
    endcase
  endfunction

  function automatic samp_t apply_sign(input logic neg, input samp_t v);
    return neg ? -v : v;
  endfunction

  // 32-bit wrapping product-accumulate of one term
  function automatic acc_t mac_term(input acc_t acc, input samp_t x, input samp_t w);
    acc_t p;
    p = acc_t'(x) * acc_t'(w);
    return acc + p;
  endfunction

  function automatic samp_t clip16(input acc_t v);
    if (v > SAT_MAX) return 16'sh7fff;
    if (v < SAT_MIN) return 16'sh8000;
    return samp_t'(v);
  endfunction
endpackage

// File: rtl/ridct_weights.sv
module ridct_weights
  import ridct_pkg::*;
(
  input  logic [ROWW-1:0] row,
  output samp_t           even_w [HALF][HALF],
  output samp_t           odd_w  [HALF][HALF],
  output acc_t            rnd
);
  logic [SETW-1:0] set;

  assign set = set_of_row(row);
  assign rnd = rounder_of_row(row);

  for (genvar k = 0; k < HALF; k++) begin : g_out
    for (genvar j = 0; j < HALF; j++) begin : g_in
      logic [2:0] ec, oc;
      assign ec = even_code(2'(k), 2'(j));
      assign oc = odd_code(2'(k), 2'(j));
      assign even_w[k][j] = apply_sign(ec[2], even_peak(set, ec[1:0]));
      assign odd_w[k][j]  = apply_sign(oc[2], odd_peak(set, oc[1:0]));
    end
  end
endmodule

// File: rtl/ridct_sums.sv
module ridct_sums
  import ridct_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [ROWW-1:0] in_row,
  input  logic [BUSW-1:0] in_coefs,
  output logic            s1_valid,
  output acc_t            even_q [HALF],
  output acc_t            odd_q  [HALF]
);
  samp_t x_even [HALF];
  samp_t x_odd  [HALF];
  samp_t even_w [HALF][HALF];
  samp_t odd_w  [HALF][HALF];
  acc_t  rnd;

  for (genvar j = 0; j < HALF; j++) begin : g_split
    assign x_even[j] = samp_t'(in_coefs[2*j*XW +: XW]);
    assign x_odd[j]  = samp_t'(in_coefs[(2*j+1)*XW +: XW]);
  end

  ridct_weights u_weights (
    .row    (in_row),
    .even_w (even_w),
    .odd_w  (odd_w),
    .rnd    (rnd)
  );

  for (genvar k = 0; k < HALF; k++) begin : g_mac
    acc_t even_d, odd_d;

    always_comb begin
      even_d = rnd;
      odd_d  = '0;
      for (int j = 0; j < HALF; j++) begin
        even_d = mac_term(even_d, x_even[j], even_w[k][j]);
        odd_d  = mac_term(odd_d,  x_odd[j],  odd_w[k][j]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        even_q[k] <= '0;
        odd_q[k]  <= '0;
      end else if (in_valid) begin
        even_q[k] <= even_d;
        odd_q[k]  <= odd_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end
endmodule

// File: rtl/ridct_out.sv
module ridct_out
  import ridct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  acc_t             even_q [HALF],
  input  acc_t             odd_q  [HALF],
  output logic [LANES-1:0] hi_clip,
  output logic [LANES-1:0] lo_clip,
  output logic             out_valid,
  output logic [BUSW-1:0]  out_coefs
);
  acc_t shifted [LANES];

  for (genvar k = 0; k < HALF; k++) begin : g_fly
    acc_t sum_w, dif_w;
    assign sum_w = even_q[k] + odd_q[k];
    assign dif_w = even_q[k] - odd_q[k];
    assign shifted[k]           = sum_w >>> SHIFT;
    assign shifted[LANES-1-k]   = dif_w >>> SHIFT;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign hi_clip[l] = s1_valid && (shifted[l] > SAT_MAX);
    assign lo_clip[l] = s1_valid && (shifted[l] < SAT_MIN);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        out_coefs[l*XW +: XW] <= '0;
      else if (s1_valid) out_coefs[l*XW +: XW] <= clip16(shifted[l]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_valid;
  end
endmodule

// File: rtl/row_idct8.sv
module row_idct8
  import ridct_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      in_row,
  input  logic [127:0]    in_coefs,
  output logic            out_valid,
  output logic [127:0]    out_coefs
);
  logic             s1_valid;
  acc_t             even_q [HALF];
  acc_t             odd_q  [HALF];
  logic [LANES-1:0] hi_clip;
  logic [LANES-1:0] lo_clip;

  ridct_sums u_sums (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_row   (in_row),
    .in_coefs (in_coefs),
    .s1_valid (s1_valid),
    .even_q   (even_q),
    .odd_q    (odd_q)
  );

  ridct_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .even_q    (even_q),
    .odd_q     (odd_q),
    .hi_clip   (hi_clip),
    .lo_clip   (lo_clip),
    .out_valid (out_valid),
    .out_coefs (out_coefs)
  );
endmodule

// File: rtl/ridct_checker.sv
module ridct_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [2:0]   in_row,
  input logic [127:0] in_coefs,
  input logic         out_valid,
  input logic [127:0] out_coefs,
  input logic         s1_valid,
  input logic [7:0]   hi_clip,
  input logic [7:0]   lo_clip
);
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s1_valid));

  a_r1_stage_link: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> $past(in_valid));

  a_r4_row4_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_row == 3'd4 && in_coefs == '0) |-> ##2 (out_coefs == '0));

  a_r4_row0_dc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_row == 3'd0 && in_coefs == '0) |-> ##2 (out_coefs == {8{16'sd32}}));

  for (genvar l = 0; l < 8; l++) begin : g_clip
    a_r7_hi_limit: assert property (@(posedge clk) disable iff (!rst_n)
      hi_clip[l] |=> (out_coefs[l*16 +: 16] == 16'h7fff));
    a_r7_lo_limit: assert property (@(posedge clk) disable iff (!rst_n)
      lo_clip[l] |=> (out_coefs[l*16 +: 16] == 16'h8000));
  end
endmodule

bind row_idct8 ridct_checker u_chk (.*);

// File: tb/row_idct8_test.sv
`timescale 1ns/1ps
module row_idct8_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   in_row = '0;
  logic [127:0] in_coefs = '0;
  logic         out_valid;
  logic [127:0] out_coefs;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  row_idct8 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_row(in_row),
    .in_coefs(in_coefs), .out_valid(out_valid), .out_coefs(out_coefs)
  );

  function automatic int clamp(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // independent restatement of the row equations, 32-bit int wraps naturally
  function automatic void model(input int row, input int x[8], output int y[8]);
    int p, q, r, ca, cb, cc, cd, rn;
    int e[4], o[4];
    case (row)
      0, 4: begin p=16384; q=21407; r=8867;  ca=22725; cb=19266; cc=12873; cd=4520; end
      1, 7: begin p=22725; q=29692; r=12299; ca=31521; cb=26722; cc=17855; cd=6270; end
      2, 6: begin p=21407; q=27969; r=11585; ca=29692; cb=25172; cc=16819; cd=5906; end
      default: begin p=19266; q=25172; r=10426; ca=26722; cb=22654; cc=15137; cd=5315; end
    endcase
    case (row)
      0: rn = 65536; 1: rn = 3597; 2: rn = 2260; 3: rn = 1203;
      4: rn = 0;     5: rn = 120;  default: rn = 512;
    endcase
    e[0] = p*x[0] + q*x[2] + p*x[4] + r*x[6] + rn;
    e[1] = p*x[0] + r*x[2] - p*x[4] - q*x[6] + rn;
    e[2] = p*x[0] - r*x[2] - p*x[4] + q*x[6] + rn;
    e[3] = p*x[0] - q*x[2] + p*x[4] - r*x[6] + rn;
    o[0] = ca*x[1] + cb*x[3] + cc*x[5] + cd*x[7];
    o[1] = cb*x[1] - cd*x[3] - ca*x[5] - cc*x[7];
    o[2] = cc*x[1] - ca*x[3] + cd*x[5] + cb*x[7];
    o[3] = cd*x[1] - cc*x[3] + cb*x[5] - ca*x[7];
    for (int k = 0; k < 4; k++) begin
      y[k]   = clamp((e[k] + o[k]) >>> 11);
      y[7-k] = clamp((e[k] - o[k]) >>> 11);
    end
  endfunction

  function automatic int lane(input logic [127:0] bus, input int j);
    return int'($signed(bus[16*j +: 16]));
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int row, input int x[8]);
    in_valid = 1'b1;
    in_row   = 3'(row);
    for (int j = 0; j < 8; j++) in_coefs[16*j +: 16] = 16'(x[j]);
  endtask

  task automatic compare(input string req, input int row, input int x[8]);
    int y[8];
    int bad;
    model(row, x, y);
    bad = -1;
    for (int j = 0; j < 8; j++) if (bad < 0 && lane(out_coefs, j) != y[j]) bad = j;
    check(out_valid === 1'b1, req, $sformatf("out_valid row %0d", row), int'(out_valid), 1);
    if (bad < 0) check(1'b1, req, "", 0, 0);
    else check(1'b0, req, $sformatf("row %0d lane %0d", row, bad), lane(out_coefs, bad), y[bad]);
  endtask

  // one row in, checked two edges later at a falling edge
  task automatic run_one(input string req, input int row, input int x[8]);
    @(negedge clk); drive(row, x);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); compare(req, row, x);
  endtask

  function automatic int rnd16();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R2", "out_valid in reset", int'(out_valid), 0);
    check(out_coefs == '0, "R2", "out_coefs in reset", int'(out_coefs[31:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "out_valid after release", int'(out_valid), 0);
    check(out_coefs == '0, "R2", "out_coefs after release", int'(out_coefs[31:0]), 0);
  endtask

  task automatic t_rounders();
    int z[8] = '{default: 0};
    int dc[8] = '{32, 1, 1, 0, 0, 0, 0, 0};
    for (int r = 0; r < 8; r++) begin
      run_one("R4", r, z);
      check(lane(out_coefs, 0) == dc[r], "R4", $sformatf("dc lane0 row %0d", r), lane(out_coefs, 0), dc[r]);
    end
  endtask

  task automatic t_impulses();
    for (int r = 0; r < 8; r++)
      for (int j = 0; j < 8; j++) begin
        int x[8] = '{default: 0};
        x[j] = (j % 2 == 0) ? 1000 : -700;
        run_one("R3", r, x);
        if (r == 4 && j == 0)
          check(lane(out_coefs, 3) == 8000, "R8", "row4 x0 impulse lane3", lane(out_coefs, 3), 8000);
      end
  endtask

  task automatic t_even_only();
    for (int r = 0; r < 8; r++) begin
      int x[8] = '{default: 0};
      for (int j = 0; j < 8; j += 2) x[j] = rnd16() / 4;
      run_one("R5", r, x);
      for (int k = 0; k < 4; k++)
        check(lane(out_coefs, k) == lane(out_coefs, 7 - k), "R5", $sformatf("even symmetry row %0d k %0d", r, k),
              lane(out_coefs, k), lane(out_coefs, 7 - k));
    end
  endtask

  task automatic t_extremes();
    int x[8];
    for (int r = 0; r < 8; r++) begin
      x = '{default: 32767};       run_one("R6", r, x);
      x = '{default: -32768};      run_one("R6", r, x);
      x = '{32767, -32768, 32767, -32768, 32767, -32768, 32767, -32768}; run_one("R6", r, x);
      x = '{-32768, 32767, 32767, -32768, -32768, 32767, 32767, -32768}; run_one("R7", r, x);
    end
    x = '{32767, 0, 0, 0, 0, 0, 0, 0};
    run_one("R7", 1, x);
    check(lane(out_coefs, 0) == 32767, "R7", "upper clip lane0", lane(out_coefs, 0), 32767);
    x = '{-32768, 0, 0, 0, 0, 0, 0, 0};
    run_one("R7", 1, x);
    check(lane(out_coefs, 0) == -32768, "R7", "lower clip lane0", lane(out_coefs, 0), -32768);
  endtask

  task automatic t_stream();
    int rows[48];
    int xs[48][8];
    for (int i = 0; i < 48; i++) begin
      rows[i] = int'($urandom_range(7));
      for (int j = 0; j < 8; j++) xs[i][j] = (i % 5 == 0) ? ((j % 2) ? -32768 : 32767) : rnd16();
    end
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (i >= 2) compare("R1", rows[i-2], xs[i-2]);
      if (i < 48) drive(rows[i], xs[i]);
      else in_valid = 1'b0;
    end
  endtask

  task automatic t_gap();
    int x[8] = '{100, 200, 300, 400, 500, 600, 700, 800};
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    drive(5, x);
    @(negedge clk); in_valid = 1'b0;
    check(out_valid == 1'b0, "R1", "out_valid one edge after input", int'(out_valid), 0);
    @(negedge clk);
    compare("R1", 5, x);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after single row", int'(out_valid), 0);
  endtask

  initial begin
    t_reset();
    t_rounders();
    t_impulses();
    t_even_only();
    t_extremes();
    t_stream();
    t_gap();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule